// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small CPU, holds each one in its own pending latch, and selects one winner per cycle by a fixed priority. The winner's 16-bit vector address goes to the CPU on a registered request/acknowledge pair. Latches are numbered 2 to 15. Latches 2 and 3 take the address-trap and watchdog requests, which cannot be masked. Latches 4 to 15 are maskable: each has its own enable bit, and all of them also need the master enable flag.

Two further non-maskable requests, software interrupt and undefined instruction, are not latched. They are level inputs that the requester holds until the CPU acknowledges, and both use the same vector. The two highest latch levels are each shared by a pair of sources, and a select bit picks which source of the pair may set that latch. Software can clear maskable latches through a write port but can never set them. When the CPU accepts a maskable interrupt, the master enable flag drops, so a nested interrupt is only taken after software sets the flag again.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every latch reads 0, `irq_req` is 0 and the master enable `imf` is 0.
- R2: A request input high at a clock edge sets its latch (latch 2 from `trap_req`, latch 3 from `wdt_req`, latch 4+k from `lvl_req[k]`). The latch stays at 1 until it is acknowledged or cleared by software.
- R3: With `clr_we` high, a 0 in bit i of `clr_data` clears latch i for i from 4 to 15. A 1 leaves the latch as it is, and no write ever sets a latch.
- R4: Latches 2 and 3 ignore software clears. Only an acknowledge of their own vector clears them.
- R5: A request that arrives in the same cycle as a software clear or an acknowledge of its latch leaves the latch set.
- R6: A maskable latch i competes only when `imf` is 1 and `en_flags[i-4]` is 1. Latch 4 also needs `ext0_en` at 1.
- R7: `swi_req`, `undef_req` and latches 2 and 3 compete whatever the state of `imf` and the enable bits. `swi_req` and `undef_req` are not latched and both present vector FFFC.
- R8: The priority order, highest first, is software/undefined, then latch 2, then latch 3, then latches 4 to 15 with the lower index winning.
- R9: The vector for slot s is FFFE − 2·s, where software/undefined is slot 1 and latch i is slot i. This gives latch 2 = FFFA, latch 3 = FFF8, latch 4 = FFF6 and latch 15 = FFE0.
- R10: For latch 14+k (k = 0, 1), `alt_sel[k]` = 0 lets `lvl_req[10+k]` set the latch and `alt_sel[k]` = 1 lets `alt_req[k]` set it. The source that is not selected has no effect.
- R11: `irq_req` and `irq_vec` are registered and show the winner computed from the state of the previous cycle. `irq_ack` while `irq_req` is 1 clears the winner's latch and forces `irq_req` low for the next cycle. `irq_ack` while `irq_req` is 0 does nothing.
- R12: `imf_set` sets `imf`. Acknowledging a maskable vector clears `imf`, acknowledging a non-maskable vector leaves it unchanged, and `imf_set` wins if both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swi_req | input | 1 | Software interrupt request, unlatched level |
| undef_req | input | 1 | Undefined-instruction request, unlatched level |
| trap_req | input | 1 | Address-trap request, sets latch 2 |
| wdt_req | input | 1 | Watchdog request, sets latch 3 |
| lvl_req | input | 12 | Maskable requests; bit k sets latch 4+k |
| alt_req | input | 2 | Alternate sources for latches 14 and 15 |
| alt_sel | input | 2 | Pair select for latches 14 and 15 (1 = alternate) |
| en_flags | input | 12 | Per-latch enables; bit k gates latch 4+k |
| ext0_en | input | 1 | Extra enable for latch 4 |
| imf_set | input | 1 | Sets the master enable flag |
| clr_we | input | 1 | Latch clear write strobe |
| clr_data | input | 16 | Clear pattern; a 0 bit clears that latch |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_req | output | 1 | A vector is presented |
| irq_vec | output | 16 | Presented vector address |
| imf | output | 1 | Master enable flag |
| lat_o | output | 16 | Pending latch state (bits 0 and 1 read 0) |

## Verification
The assertions check on every cycle that an acknowledge drops the request for one cycle and that the protected latches survive everything except their own acknowledge. They also check that a latch 2 can only rise from a trap request, that a maskable vector never appears unless the master enable was set, that an unlatched software request is presented on the next cycle, and that a maskable acknowledge clears the master enable. The bench's scenarios are needed for the rest: the full priority order among several pending sources, the pair select on the shared levels, the extra enable on latch 4, and set-beats-clear collisions. It drives these scenarios against a behavioural model of latches, flag and handshake.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // first maskable latch; slots below it are fixed non-maskable sources
   localparam int unsigned FIRST_MASK = 4;
   localparam int unsigned SLOT_SOFT  = 1;
   localparam int unsigned SLOT_TRAP  = 2;
   localparam int unsigned SLOT_WDT   = 3;
endpackage

// File: rtl/intc_latch_bank.sv
module intc_latch_bank
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned N_MUX   = 2,
   parameter int unsigned IDX_W   = $clog2(NUM_LVL)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    trap_req,
   input  logic                    wdt_req,
   input  logic [NUM_LVL-5:0]      lvl_req,
   input  logic [N_MUX-1:0]        alt_req,
   input  logic [N_MUX-1:0]        alt_sel,
   input  logic                    clr_we,
   input  logic [NUM_LVL-1:0]      clr_data,
   input  logic                    ack_clr,
   input  logic [IDX_W-1:0]        ack_slot,
   output logic [NUM_LVL-1:0]      lat
);
   localparam int unsigned MUX_BASE = NUM_LVL - N_MUX;

   for (genvar i = 0; i < NUM_LVL; i++) begin : g_lat
      if (i < int'(SLOT_TRAP)) begin : g_none
         assign lat[i] = 1'b0;
      end else begin : g_real
         logic set_w;
         logic drop_w;
         if (i == int'(SLOT_TRAP)) begin : g_trap
            assign set_w = trap_req;
         end else if (i == int'(SLOT_WDT)) begin : g_wdt
            assign set_w = wdt_req;
         end else if (i >= int'(MUX_BASE)) begin : g_mux
            localparam int K = i - int'(MUX_BASE);
            assign set_w = alt_sel[K] ? alt_req[K] : lvl_req[i-int'(FIRST_MASK)];
         end else begin : g_plain
            assign set_w = lvl_req[i-int'(FIRST_MASK)];
         end
         if (i >= int'(FIRST_MASK)) begin : g_swclr
            assign drop_w = (clr_we && !clr_data[i]) ||
                            (ack_clr && ack_slot == IDX_W'(i));
         end else begin : g_prot
            // protected latch: only its own acknowledge drops it
            assign drop_w = ack_clr && ack_slot == IDX_W'(i);
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      lat[i] <= 1'b0;
            else if (set_w)  lat[i] <= 1'b1;
            else if (drop_w) lat[i] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned IDX_W   = $clog2(NUM_LVL)
) (
   input  logic [NUM_LVL-1:0] lat,
   input  logic               imf,
   input  logic [NUM_LVL-5:0] en_flags,
   input  logic               ext0_en,
   input  logic               soft_req,
   output logic               hit,
   output logic [IDX_W-1:0]   slot
);
   always_comb begin
      hit  = 1'b0;
      slot = '0;
      // scan lowest priority first so the strongest source is written last
      for (int i = int'(NUM_LVL) - 1; i >= int'(FIRST_MASK); i--) begin
         if (lat[i] && imf && en_flags[i-int'(FIRST_MASK)] &&
             (i != int'(FIRST_MASK) || ext0_en)) begin
            hit  = 1'b1;
            slot = IDX_W'(i);
         end
      end
      if (lat[SLOT_WDT]) begin
         hit  = 1'b1;
         slot = IDX_W'(SLOT_WDT);
      end
      if (lat[SLOT_TRAP]) begin
         hit  = 1'b1;
         slot = IDX_W'(SLOT_TRAP);
      end
      if (soft_req) begin
         hit  = 1'b1;
         slot = IDX_W'(SLOT_SOFT);
      end
   end
endmodule

// File: rtl/intc_handshake.sv
module intc_handshake
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned VEC_W   = 16,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE,
   parameter int unsigned IDX_W   = $clog2(NUM_LVL)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic [IDX_W-1:0]   slot,
   input  logic               irq_ack,
   input  logic               imf_set,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic               imf,
   output logic               ack_clr,
   output logic [IDX_W-1:0]   ack_slot
);
   logic [IDX_W-1:0] slot_q;
   logic             accept;

   assign accept   = irq_req && irq_ack;
   assign ack_clr  = accept;
   assign ack_slot = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
         slot_q  <= '0;
      end else begin
         // one bubble after an accept lets the latch clear take effect
         irq_req <= accept ? 1'b0 : hit;
         slot_q  <= slot;
         irq_vec <= VEC_TOP - VEC_W'({slot, 1'b0});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         imf <= 1'b0;
      else if (imf_set)
         imf <= 1'b1;
      else if (accept && slot_q >= IDX_W'(FIRST_MASK))
         imf <= 1'b0;
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import intc_pkg::*;
#(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned N_MUX   = 2,
   parameter int unsigned VEC_W   = 16,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               swi_req,
   input  logic               undef_req,
   input  logic               trap_req,
   input  logic               wdt_req,
   input  logic [NUM_LVL-5:0] lvl_req,
   input  logic [N_MUX-1:0]   alt_req,
   input  logic [N_MUX-1:0]   alt_sel,
   input  logic [NUM_LVL-5:0] en_flags,
   input  logic               ext0_en,
   input  logic               imf_set,
   input  logic               clr_we,
   input  logic [NUM_LVL-1:0] clr_data,
   input  logic               irq_ack,
   output logic               irq_req,
   output logic [VEC_W-1:0]   irq_vec,
   output logic               imf,
   output logic [NUM_LVL-1:0] lat_o
);
   localparam int unsigned IDX_W = $clog2(NUM_LVL);

   if (NUM_LVL < FIRST_MASK + N_MUX + 1) begin : g_bad_lvl
      $error("NUM_LVL too small for the fixed slots and shared levels");
   end
   if (N_MUX < 1) begin : g_bad_mux
      $error("N_MUX must be at least 1");
   end
   if (int'(VEC_TOP) < 2 * int'(NUM_LVL)) begin : g_bad_vec
      $error("VEC_TOP leaves no room for all vectors");
   end

   logic             hit;
   logic [IDX_W-1:0] slot;
   logic             ack_clr;
   logic [IDX_W-1:0] ack_slot;

   intc_latch_bank #(.NUM_LVL(NUM_LVL), .N_MUX(N_MUX), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .wdt_req(wdt_req),
      .lvl_req(lvl_req), .alt_req(alt_req), .alt_sel(alt_sel),
      .clr_we(clr_we), .clr_data(clr_data),
      .ack_clr(ack_clr), .ack_slot(ack_slot), .lat(lat_o)
   );

   intc_prio_pick #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_pick (
      .lat(lat_o), .imf(imf), .en_flags(en_flags), .ext0_en(ext0_en),
      .soft_req(swi_req | undef_req), .hit(hit), .slot(slot)
   );

   intc_handshake #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP),
                    .IDX_W(IDX_W)) u_hs (
      .clk(clk), .rst_n(rst_n), .hit(hit), .slot(slot),
      .irq_ack(irq_ack), .imf_set(imf_set),
      .irq_req(irq_req), .irq_vec(irq_vec), .imf(imf),
      .ack_clr(ack_clr), .ack_slot(ack_slot)
   );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int unsigned NUM_LVL = 16,
   parameter int unsigned VEC_W   = 16,
   parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE
) (
   input logic               clk,
   input logic               rst_n,
   input logic               swi_req,
   input logic               undef_req,
   input logic               trap_req,
   input logic               imf_set,
   input logic               irq_ack,
   input logic               irq_req,
   input logic [VEC_W-1:0]   irq_vec,
   input logic               imf,
   input logic [NUM_LVL-1:0] lat_o
);
   localparam logic [VEC_W-1:0] V_SOFT = VEC_TOP - VEC_W'(2);
   localparam logic [VEC_W-1:0] V_TRAP = VEC_TOP - VEC_W'(4);
   localparam logic [VEC_W-1:0] V_WDT  = VEC_TOP - VEC_W'(6);
   localparam logic [VEC_W-1:0] V_MASK = VEC_TOP - VEC_W'(8);

   a_r11_ack_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req);

   a_r2_trap_only_by_req: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_o[2] && !trap_req |=> !lat_o[2]);

   a_r4_trap_protected: assert property (@(posedge clk) disable iff (!rst_n)
      lat_o[2] && !(irq_req && irq_ack && irq_vec == V_TRAP) |=> lat_o[2]);

   a_r4_wdt_protected: assert property (@(posedge clk) disable iff (!rst_n)
      lat_o[3] && !(irq_req && irq_ack && irq_vec == V_WDT) |=> lat_o[3]);

   a_r6_mask_needs_imf: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_vec <= V_MASK |-> $past(imf));

   a_r7_soft_next: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_req || undef_req) && !(irq_req && irq_ack) |=> irq_req && irq_vec == V_SOFT);

   a_r12_imf_drop: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && irq_vec <= V_MASK && !imf_set |=> !imf);
endmodule

bind prio_vec_intc intc_chk #(.NUM_LVL(NUM_LVL), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP)) u_chk (
   .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .undef_req(undef_req),
   .trap_req(trap_req), .imf_set(imf_set), .irq_ack(irq_ack),
   .irq_req(irq_req), .irq_vec(irq_vec), .imf(imf), .lat_o(lat_o)
);

// File: tb/test_prio_vec_intc.sv
`timescale 1ns/1ps
module test_prio_vec_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        swi_req = 0, undef_req = 0, trap_req = 0, wdt_req = 0;
   logic [11:0] lvl_req = '0;
   logic [1:0]  alt_req = '0, alt_sel = '0;
   logic [11:0] en_flags = '0;
   logic        ext0_en = 0, imf_set = 0, clr_we = 0, irq_ack = 0;
   logic [15:0] clr_data = '1;
   logic        irq_req, imf;
   logic [15:0] irq_vec, lat_o;

   int n_run = 0, n_fail = 0;
   bit cmp_on = 0;

   always #4 clk = ~clk;

   prio_vec_intc i_prio_vec_intc (
      .clk(clk), .rst_n(rst_n), .swi_req(swi_req), .undef_req(undef_req),
      .trap_req(trap_req), .wdt_req(wdt_req), .lvl_req(lvl_req),
      .alt_req(alt_req), .alt_sel(alt_sel), .en_flags(en_flags),
      .ext0_en(ext0_en), .imf_set(imf_set), .clr_we(clr_we),
      .clr_data(clr_data), .irq_ack(irq_ack), .irq_req(irq_req),
      .irq_vec(irq_vec), .imf(imf), .lat_o(lat_o)
   );

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [15:0] m_lat;
   bit        m_imf, m_req;
   int        m_slot;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lat = '0; m_imf = 0; m_req = 0; m_slot = 0;
      end else begin
         int  win;
         bit  acc;
         bit [15:0] setv;
         win = 0;
         if (swi_req || undef_req) win = 1;
         else if (m_lat[2]) win = 2;
         else if (m_lat[3]) win = 3;
         else begin
            for (int i = 4; i < 16; i++)
               if (win == 0 && m_lat[i] && m_imf && en_flags[i-4] && (i != 4 || ext0_en))
                  win = i;
         end
         acc = m_req && irq_ack;
         setv = '0;
         setv[2] = trap_req;
         setv[3] = wdt_req;
         for (int i = 4; i < 14; i++) setv[i] = lvl_req[i-4];
         setv[14] = alt_sel[0] ? alt_req[0] : lvl_req[10];
         setv[15] = alt_sel[1] ? alt_req[1] : lvl_req[11];
         for (int i = 2; i < 16; i++) begin
            if (setv[i]) m_lat[i] = 1;
            else if (acc && m_slot == i) m_lat[i] = 0;
            else if (i >= 4 && clr_we && !clr_data[i]) m_lat[i] = 0;
         end
         if (imf_set) m_imf = 1;
         else if (acc && m_slot >= 4) m_imf = 0;
         m_req  = acc ? 0 : (win != 0);
         m_slot = win;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2 latch state vs model", {16'h0, lat_o}, {16'h0, m_lat});
         chk("R11 request vs model", {31'h0, irq_req}, {31'h0, m_req});
         chk("R12 imf vs model", {31'h0, imf}, {31'h0, m_imf});
         if (m_req)
            chk("R9 vector vs model", {16'h0, irq_vec}, 16'hFFFE - 2 * m_slot);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ack_once();
      irq_ack = 1; tick(1); irq_ack = 0;
   endtask

   task automatic clear_write(logic [15:0] d);
      clr_we = 1; clr_data = d; tick(1); clr_we = 0; clr_data = '1;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      // R1 reset state
      chk("R1 latches after reset", {16'h0, lat_o}, 0);
      chk("R1 irq_req after reset", {31'h0, irq_req}, 0);
      chk("R1 imf after reset", {31'h0, imf}, 0);
      cmp_on = 1;

      en_flags = '1; ext0_en = 1;
      // R2 / R6: latch 6 pends, masked while imf is 0
      lvl_req[2] = 1; tick(1); lvl_req[2] = 0;
      chk("R2 latch 6 set", {31'h0, lat_o[6]}, 1);
      tick(2);
      chk("R6 masked without imf", {31'h0, irq_req}, 0);
      imf_set = 1; tick(1); imf_set = 0;
      tick(2);
      chk("R9 latch 6 vector", {15'h0, irq_req, irq_vec}, {15'h0, 1'b1, 16'hFFF2});
      ack_once();
      tick(1);
      chk("R11 latch 6 cleared by ack", {31'h0, lat_o[6]}, 0);
      chk("R12 imf cleared by maskable ack", {31'h0, imf}, 0);

      // R8 maskable order: latches 5 and 9
      lvl_req[1] = 1; lvl_req[5] = 1; imf_set = 1; tick(1);
      lvl_req = '0; imf_set = 0; tick(2);
      chk("R8 latch 5 before 9", {16'h0, irq_vec}, 16'hFFF4);
      ack_once();
      imf_set = 1; tick(1); imf_set = 0; tick(2);
      chk("R8 latch 9 next", {16'h0, irq_vec}, 16'hFFEC);
      ack_once(); tick(2);

      // R7 / R8 non-maskable: trap before watchdog, imf untouched
      trap_req = 1; wdt_req = 1; tick(1); trap_req = 0; wdt_req = 0; tick(2);
      chk("R7 trap ignores imf", {15'h0, irq_req, irq_vec}, {15'h0, 1'b1, 16'hFFFA});
      ack_once(); tick(2);
      chk("R8 watchdog after trap", {16'h0, irq_vec}, 16'hFFF8);
      chk("R12 imf unchanged by nmi ack", {31'h0, imf}, 0);
      ack_once(); tick(2);
      chk("R11 idle after acks", {31'h0, irq_req}, 0);

      // R7 software request, unlatched
      lvl_req[3] = 1; tick(1); lvl_req[3] = 0;
      swi_req = 1; tick(2);
      chk("R7 soft vector", {16'h0, irq_vec}, 16'hFFFC);
      irq_ack = 1; tick(1); irq_ack = 0; swi_req = 0; tick(2);
      chk("R7 soft not latched", {31'h0, irq_req}, 0);
      chk("R6 latch 7 still pending", {31'h0, lat_o[7]}, 1);

      // R3 / R4 software clear
      trap_req = 1; tick(1); trap_req = 0; tick(1);
      clear_write(16'h0000); tick(1);
      chk("R4 trap latch survives clear", {31'h0, lat_o[2]}, 1);
      chk("R3 latch 7 cleared", {31'h0, lat_o[7]}, 0);
      ack_once(); tick(2);
      lvl_req[4] = 1; tick(1); lvl_req[4] = 0;
      clear_write(16'hFFFF); tick(1);
      chk("R3 ones neither clear nor set", {16'h0, lat_o}, 16'h0100);

      // R5 request beats clear
      lvl_req[3] = 1; clr_we = 1; clr_data = 16'h0000; tick(1);
      lvl_req[3] = 0; clr_we = 0; clr_data = '1; tick(1);
      chk("R5 set wins over clear", {16'h0, lat_o}, 16'h0080);

      // R10 shared levels
      clear_write(16'h0000);
      alt_sel = 2'b01;
      lvl_req[10] = 1; tick(1); lvl_req[10] = 0; tick(1);
      chk("R10 unselected source ignored", {31'h0, lat_o[14]}, 0);
      alt_req[0] = 1; tick(1); alt_req[0] = 0; tick(1);
      chk("R10 alternate sets latch 14", {31'h0, lat_o[14]}, 1);
      alt_req[1] = 1; tick(1); alt_req[1] = 0; tick(1);
      chk("R10 alternate ignored on 15", {31'h0, lat_o[15]}, 0);
      lvl_req[11] = 1; tick(1); lvl_req[11] = 0; tick(1);
      chk("R10 primary sets latch 15", {31'h0, lat_o[15]}, 1);
      clear_write(16'h0000); alt_sel = 2'b00; tick(1);

      // R6 extra enable on latch 4
      ext0_en = 0; imf_set = 1; lvl_req[0] = 1; tick(1);
      imf_set = 0; lvl_req[0] = 0; tick(2);
      chk("R6 latch 4 needs ext0_en", {31'h0, irq_req}, 0);
      ext0_en = 1; tick(2);
      chk("R9 latch 4 vector", {16'h0, irq_vec}, 16'hFFF6);
      ack_once(); tick(1);
      chk("R12 imf cleared", {31'h0, imf}, 0);

      // R11 ack without request
      lvl_req[5] = 1; tick(1); lvl_req[5] = 0; tick(1);
      ack_once(); tick(1);
      chk("R11 idle ack ignored", {16'h0, lat_o}, 16'h0200);
      clear_write(16'h0000); tick(1);

      // mixed traffic against the model
      for (int c = 0; c < 4000; c++) begin
         swi_req   = ($urandom % 23) == 0;
         undef_req = ($urandom % 29) == 0;
         trap_req  = ($urandom % 31) == 0;
         wdt_req   = ($urandom % 31) == 0;
         lvl_req   = 12'($urandom) & 12'($urandom) & 12'($urandom);
         alt_req   = 2'($urandom);
         if (($urandom % 50) == 0) alt_sel = 2'($urandom);
         if (($urandom % 40) == 0) en_flags = 12'($urandom);
         if (($urandom % 40) == 0) ext0_en = 1'($urandom);
         imf_set   = ($urandom % 8) == 0;
         clr_we    = ($urandom % 16) == 0;
         clr_data  = 16'($urandom);
         irq_ack   = ($urandom % 3) == 0;
         tick(1);
      end
      swi_req = 0; undef_req = 0; trap_req = 0; wdt_req = 0; lvl_req = '0;
      alt_req = '0; imf_set = 0; clr_we = 0; irq_ack = 0;
      tick(2);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule